// File: doc/BRIEF.md
# Multiprocessor Serial Address Filter

This block sits behind the receiver of a multiprocessor serial port. It looks at every completed frame and decides whether the receive-interrupt flag should be raised. The bit-level receiver hands it the received byte, the ninth data bit and the stop-bit status as a parallel word, together with a one-cycle frame-done strobe. The CPU sees an interrupt only for frames that are meant for this node, so traffic addressed to other nodes on a shared line costs no software time.

Filtering is switched on by a multiprocessor enable input. While it is off, every frame raises the flag. While it is on, a frame must carry the address marker and must match one of two patterns. The marker is the ninth bit in 9-bit mode and a valid stop bit in 8-bit mode. The first pattern is the node's own address, qualified by a per-bit care mask, which allows group addressing. The second is a broadcast pattern derived from the same two registers. The address and mask registers are loaded through a small write port and both clear to zero, which makes the node accept any address until it is configured.

Top module: `addr_match_filter`

## Requirements
- R1: After reset the output is low, and both the own-address register and the care-mask register hold zero. With filtering on, any frame that carries the marker therefore raises the flag.
- R2: While `mp_en` is 0, every frame-done strobe raises the flag, whatever the byte, ninth bit and stop bit are.
- R3: With filtering on, a frame carrying the marker matches its own address when, at every bit position where the care mask is 1, the byte agrees with the own-address register. Positions where the mask is 0 are ignored.
- R4: With a care mask of all ones, only the exact own address matches its own-address pattern. Any other byte raises the flag only if it meets R5.
- R5: The broadcast pattern is the bitwise OR of the own-address and care-mask registers. A frame carrying the marker matches it when the byte has a 1 at every position where that pattern has a 1.
- R6: In 9-bit mode (`wide_mode` = 1) with filtering on, a frame whose ninth bit is 0 is a data frame and raises no flag. In this mode `frm_stop` has no effect.
- R7: In 8-bit mode (`wide_mode` = 0) with filtering on, the stop bit is the marker: a matching frame raises the flag only when `frm_stop` is 1. In this mode `frm_bit9` has no effect.
- R8: The flag is a one-cycle pulse. It is high exactly in the cycle after the clock edge that samples `frm_done` high. It is never high without a strobe.
- R9: When `cfg_we` is 1, `cfg_sel` = 0 loads the own-address register and `cfg_sel` = 1 loads the care mask. A write made in the same cycle as a strobe does not affect that frame. It applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Write target: 0 own address, 1 care mask |
| cfg_wdata | input | W | Write data |
| frm_done | input | 1 | One-cycle strobe marking a completed frame |
| frm_byte | input | W | Received data or address byte |
| frm_bit9 | input | 1 | Received ninth bit (9-bit mode) |
| frm_stop | input | 1 | Stop bit was valid (8-bit mode) |
| wide_mode | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| mp_en | input | 1 | Enables address filtering |
| rx_flag_set | output | 1 | One-cycle pulse that sets the receive-interrupt flag |

## Verification
Only one result is due. The flag pulse for a strobe sampled at a rising edge must be visible in the following cycle, and it must be gone one cycle after that. A register write takes effect at the same edge, so it changes only the decision for the next frame. The bench drives all inputs on falling edges. A behavioural model in the bench computes the expected flag at each rising edge from the inputs and its own copy of the registers, and the output is compared with that model at every falling edge. The directed frame task also reads the flag at the falling edge after the strobe edge, and checks that it is low again one cycle later.

// File: rtl/addr_match_filter.sv
module addr_match_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic         cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  input  logic         frm_done,
  input  logic [W-1:0] frm_byte,
  input  logic         frm_bit9,
  input  logic         frm_stop,
  input  logic         wide_mode,
  input  logic         mp_en,
  output logic         rx_flag_set
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] own_q, care_q;
  logic [W-1:0] bcast;
  logic         marker, hit_own, hit_bcast, accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= '0;
      care_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) care_q <= cfg_wdata;
      else         own_q  <= cfg_wdata;
    end
  end

  assign bcast     = own_q | care_q;
  assign marker    = wide_mode ? frm_bit9 : frm_stop;
  assign hit_own   = ((frm_byte ^ own_q) & care_q) == '0;
  assign hit_bcast = (~frm_byte & bcast) == '0;
  assign accept    = !mp_en || (marker && (hit_own || hit_bcast));

  always_ff @(posedge clk) begin
    if (!rst_n) rx_flag_set <= 1'b0;
    else        rx_flag_set <= frm_done && accept;
  end

  // R8
  flag_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag_set |-> $past(frm_done));

  // R2
  unfiltered_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !mp_en) |=> rx_flag_set);

  // R6
  data_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && mp_en && wide_mode && !frm_bit9) |=> !rx_flag_set);

  // R7
  bad_stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && mp_en && !wide_mode && !frm_stop) |=> !rx_flag_set);

  // R4
  exact_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && mp_en && care_q == ONES && frm_byte != own_q && frm_byte != ONES)
      |=> !rx_flag_set);

endmodule

// File: tb/addr_match_filter_tb.sv
`timescale 1ns/1ps
module addr_match_filter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic         frm_done = 1'b0;
  logic [W-1:0] frm_byte = '0;
  logic         frm_bit9 = 1'b0, frm_stop = 1'b0;
  logic         wide_mode = 1'b1, mp_en = 1'b0;
  logic         rx_flag_set;

  int    total = 0, bad = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  addr_match_filter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frm_done(frm_done), .frm_byte(frm_byte),
    .frm_bit9(frm_bit9), .frm_stop(frm_stop), .wide_mode(wide_mode),
    .mp_en(mp_en), .rx_flag_set(rx_flag_set)
  );

  always #2 clk = ~clk;

  // behavioural reference
  logic [W-1:0] m_own, m_care;
  logic         exp_q = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = '0; m_care = '0; exp_q = 1'b0;
    end else begin
      bit mk, ok_own, ok_bc;
      mk = wide_mode ? frm_bit9 : frm_stop;
      ok_own = 1; ok_bc = 1;
      for (int i = 0; i < W; i++) begin
        if (m_care[i] && frm_byte[i] != m_own[i]) ok_own = 0;
        if ((m_own[i] || m_care[i]) && !frm_byte[i]) ok_bc = 0;
      end
      exp_q = frm_done && (!mp_en || (mk && (ok_own || ok_bc)));
      if (cfg_we) begin
        if (cfg_sel) m_care = cfg_wdata;
        else         m_own  = cfg_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input bit act, input bit exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !finished) check(rx_flag_set === exp_q, cur_req, rx_flag_set, exp_q);

  task automatic cfg(input bit sel, input logic [W-1:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic frame(input logic [W-1:0] b, input bit b9, input bit st,
                       input bit expv, input string req);
    frm_done = 1; frm_byte = b; frm_bit9 = b9; frm_stop = st;
    @(negedge clk);
    frm_done = 0; cfg_we = 0;
    check(rx_flag_set === expv, req, rx_flag_set, expv);
    @(negedge clk);
    check(rx_flag_set === 1'b0, "R8", rx_flag_set, 1'b0);
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 1'b0, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rx_flag_set === 1'b0, "R1", rx_flag_set, 1'b0);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1"; mp_en = 1; wide_mode = 1;
    frame(8'h5A, 1, 0, 1, "R1");
    cur_req = "R8";
    repeat (3) @(negedge clk);
    check(rx_flag_set === 1'b0, "R8", rx_flag_set, 1'b0);

    cur_req = "R2"; mp_en = 0;
    frame(8'h33, 0, 0, 1, "R2");
    cfg(1, 8'hFF); cfg(0, 8'h12);
    frame(8'h00, 0, 0, 1, "R2");

    mp_en = 1; cur_req = "R3";
    cfg(0, 8'hA5); cfg(1, 8'hF0);
    frame(8'hA3, 1, 0, 1, "R3");
    frame(8'hB5, 1, 0, 0, "R3");
    cur_req = "R5";
    frame(8'hF7, 1, 0, 1, "R5");
    cur_req = "R6";
    frame(8'hA3, 0, 1, 0, "R6");

    cur_req = "R4";
    cfg(0, 8'h3C); cfg(1, 8'hFF);
    frame(8'h3C, 1, 0, 1, "R4");
    frame(8'h3D, 1, 0, 0, "R4");
    cur_req = "R5";
    frame(8'hFF, 1, 0, 1, "R5");

    cur_req = "R7"; wide_mode = 0;
    frame(8'h3C, 1, 0, 0, "R7");
    frame(8'h3C, 0, 1, 1, "R7");

    cur_req = "R9"; wide_mode = 1;
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 8'h00;
    frame(8'h11, 1, 0, 0, "R9");
    frame(8'h11, 1, 0, 1, "R9");

    cur_req = "R8";
    for (int n = 0; n < 400; n++) begin
      cfg_we    = ($urandom % 8) == 0;
      cfg_sel   = $urandom;
      cfg_wdata = $urandom;
      frm_done  = $urandom;
      frm_byte  = (($urandom % 3) == 0) ? 8'hFF : W'($urandom);
      frm_bit9  = $urandom;
      frm_stop  = $urandom;
      wide_mode = $urandom;
      mp_en     = ($urandom % 4) != 0;
      @(negedge clk);
    end
    frm_done = 0; cfg_we = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule